// File: doc/BRIEF.md
# Phase-Adjustable IQ Downconverter

This block mixes a stream of real, signed IF samples down to baseband I and Q. A phase accumulator advances by a 45-bit tuning word once for every accepted sample. A 24-bit signed phase offset is added to the top of the accumulator. The top bits of that sum address a quarter-wave sine table, which supplies cosine and sine together. Because the offset moves both oscillator outputs at once, it rotates the whole IQ constellation.

The tuning and offset words are captured only on a trigger pulse. The same pulse returns the accumulator to zero, so every readout window starts from the same oscillator phase. Software can change the control words at any time without disturbing a window that is already running. The oscillator frequency is `ftw * fs / 2^45`, so a 45-bit word resolves to microhertz and covers 0 to 200 MHz at the usual sample rates.

Each product is rounded and saturated to 16 bits. A result appears two clock cycles after its sample is accepted.

Top module: `iq_ddc`

## Requirements
- R1: While reset is asserted and until the first sample has passed through, `out_valid` is 0 and `out_i` and `out_q` are 0. The captured tuning and offset words reset to 0.
- R2: A sample accepted with `in_valid`=1 on a clock edge produces its result on the second rising edge after it. `out_valid` is high for exactly one cycle per accepted sample.
- R3: The n-th accepted sample after a trigger (n=0 is the first) uses accumulator value `n*ftw mod 2^45`. Cycles with `in_valid`=0 do not advance the accumulator.
- R4: The phase word is `acc[44:21] + pofs` (mod 2^24), where `pofs` is two's complement and 0x800000 means 180 degrees. Its top 10 bits form the index p. The oscillator angle is `2*pi*(p+0.5)/1024`.
- R5: The table amplitude is 32767. The outputs are I = round(x*32767*cos/32768) and Q = round(-x*32767*sin/32768), rounded half up and saturated to 16-bit signed.
- R6: `ftw_in` and `pofs_in` are sampled only on a cycle with `trig`=1. Changing them at any other time has no effect on the outputs.
- R7: `trig` clears the accumulator. A sample accepted in the trigger cycle itself uses n=0 and the new words. Two shots with the same words give identical outputs.
- R8: `out_i` and `out_q` hold their last value while no new result is produced.
- R9: `out_i` and `out_q` never take the value -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Captures the control words and clears the phase |
| ftw_in | input | 45 | Frequency tuning word, unsigned |
| pofs_in | input | 24 | Phase offset word, signed |
| in_valid | input | 1 | Marks an IF sample on `in_x` |
| in_x | input | 16 | IF sample, signed |
| out_valid | output | 1 | Marks a result on `out_i` and `out_q` |
| out_i | output | 16 | In-phase result, signed |
| out_q | output | 16 | Quadrature result, signed |

## Verification
The latency property assumes `in_valid` is held low while reset is asserted. It compares only once three edges have passed since reset, and the bench drives `in_valid` to 0 before releasing reset. The offset property expects the phase word to equal `pofs_in` in any trigger cycle, which holds for any input values. The bench drives `trig`, `ftw_in` and `pofs_in` only on falling edges, so every control word is stable at the capturing edge. Expected results come from real-valued trigonometry with a two-LSB tolerance, because the bench does not copy the design's table quantisation.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  // fixed-point format used while building the quarter-wave table
  localparam int     SIN_FRAC  = 28;
  localparam longint HALF_PI_Q = 64'sd421657428;   // pi/2 * 2^28

  // amplitude * sin(pi/2 * (k + 0.5) / n), rounded, by an integer Taylor series
  function automatic longint quarter_sine(input int k, input int n, input int amp);
    longint x, x2, term, sum;
    x    = (HALF_PI_Q * longint'(2 * k + 1)) / longint'(2 * n);
    x2   = (x * x) >>> SIN_FRAC;
    term = x;
    sum  = x;
    for (int i = 1; i <= 6; i++) begin
      term = (-((term * x2) >>> SIN_FRAC)) / longint'((2 * i) * (2 * i + 1));
      sum  = sum + term;
    end
    return (sum * longint'(amp) + (64'sd1 <<< (SIN_FRAC - 1))) >>> SIN_FRAC;
  endfunction
endpackage

// File: rtl/ddc_phase_acc.sv
module ddc_phase_acc #(
  parameter int FTW_W = 45,
  parameter int PH_W  = 24,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             in_valid,
  input  logic [FTW_W-1:0] ftw_in,
  input  logic [PH_W-1:0]  pofs_in,
  output logic [FTW_W-1:0] acc_q,
  output logic [FTW_W-1:0] ftw_act,
  output logic [PH_W-1:0]  pofs_act,
  output logic [PH_W-1:0]  ph,
  output logic [IDX_W-1:0] idx
);
  logic [FTW_W-1:0] acc_base, ftw_use;
  logic [PH_W-1:0]  pofs_use;

  // a trigger acts on the sample of its own cycle
  always_comb begin
    acc_base = trig ? '0      : acc_q;
    ftw_use  = trig ? ftw_in  : ftw_act;
    pofs_use = trig ? pofs_in : pofs_act;
    ph       = acc_base[FTW_W-1 -: PH_W] + pofs_use;
    idx      = ph[PH_W-1 -: IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      ftw_act  <= '0;
      pofs_act <= '0;
    end else begin
      if (trig) begin
        ftw_act  <= ftw_in;
        pofs_act <= pofs_in;
      end
      acc_q <= in_valid ? acc_base + ftw_use : acc_base;
    end
  end
endmodule

// File: rtl/ddc_sincos_lut.sv
module ddc_sincos_lut #(
  parameter int IDX_W = 10,
  parameter int AMP_W = 16,
  parameter int IN_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [IDX_W-1:0]        idx,
  input  logic signed [IN_W-1:0]  x,
  output logic                    vld_q,
  output logic signed [IN_W-1:0]  x_q,
  output logic signed [AMP_W-1:0] cos_q,
  output logic signed [AMP_W-1:0] sin_q
);
  localparam int QN      = 1 << (IDX_W - 2);
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

  logic [AMP_W-1:0] qtab [QN];

  for (genvar k = 0; k < QN; k++) begin : g_tab
    localparam longint VAL = ddc_pkg::quarter_sine(k, QN, AMP_MAX);
    assign qtab[k] = AMP_W'(VAL);
  end

  // full-cycle sine from the quarter table: mirror in odd quadrants, negate in the lower half
  function automatic logic signed [AMP_W-1:0] wave(input logic [IDX_W-1:0] p);
    logic [IDX_W-3:0] k;
    logic [AMP_W-1:0] m;
    k = p[IDX_W-2] ? ~p[IDX_W-3:0] : p[IDX_W-3:0];
    m = qtab[k];
    return p[IDX_W-1] ? -$signed(m) : $signed(m);
  endfunction

  logic [IDX_W-1:0] idx_c;
  assign idx_c = idx + IDX_W'(QN);   // cosine leads sine by a quarter turn

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      cos_q <= '0;
      sin_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        x_q   <= x;
        cos_q <= wave(idx_c);
        sin_q <= wave(idx);
      end
    end
  end
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
  parameter int IN_W  = 16,
  parameter int AMP_W = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld,
  input  logic signed [IN_W-1:0]  x,
  input  logic signed [AMP_W-1:0] c,
  input  logic signed [AMP_W-1:0] s,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] oi,
  output logic signed [OUT_W-1:0] oq
);
  localparam int PW = IN_W + AMP_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (AMP_W - 2);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (OUT_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (OUT_W - 1));

  // scale back by the table amplitude, round half up, clamp to the output range
  function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] r;
    r = (p + HALF) >>> (AMP_W - 1);
    if (r > MAXV) return MAXV[OUT_W-1:0];
    if (r < MINV) return MINV[OUT_W-1:0];
    return r[OUT_W-1:0];
  endfunction

  logic signed [PW-1:0] pi, pq;
  assign pi = PW'(x) * PW'(c);
  assign pq = -(PW'(x) * PW'(s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      oi      <= '0;
      oq      <= '0;
    end else begin
      out_vld <= vld;
      if (vld) begin
        oi <= round_sat(pi);
        oq <= round_sat(pq);
      end
    end
  end
endmodule

// File: rtl/iq_ddc.sv
module iq_ddc #(
  parameter int IN_W  = 16,
  parameter int FTW_W = 45,
  parameter int PH_W  = 24,
  parameter int IDX_W = 10,
  parameter int AMP_W = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig,
  input  logic [FTW_W-1:0]        ftw_in,
  input  logic [PH_W-1:0]         pofs_in,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_x,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  // named internal events for the checker
  logic [FTW_W-1:0]        acc_q, ftw_act;
  logic [PH_W-1:0]         pofs_act, ph;
  logic [IDX_W-1:0]        idx;
  logic                    lut_vld;
  logic signed [IN_W-1:0]  lut_x;
  logic signed [AMP_W-1:0] lut_cos, lut_sin;

  ddc_phase_acc #(.FTW_W(FTW_W), .PH_W(PH_W), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .trig(trig), .in_valid(in_valid),
    .ftw_in(ftw_in), .pofs_in(pofs_in), .acc_q(acc_q), .ftw_act(ftw_act),
    .pofs_act(pofs_act), .ph(ph), .idx(idx)
  );

  ddc_sincos_lut #(.IDX_W(IDX_W), .AMP_W(AMP_W), .IN_W(IN_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .idx(idx), .x(in_x),
    .vld_q(lut_vld), .x_q(lut_x), .cos_q(lut_cos), .sin_q(lut_sin)
  );

  ddc_mixer #(.IN_W(IN_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .vld(lut_vld), .x(lut_x), .c(lut_cos), .s(lut_sin),
    .out_vld(out_valid), .oi(out_i), .oq(out_q)
  );
endmodule

// File: rtl/iq_ddc_chk.sv
module iq_ddc_chk #(
  parameter int FTW_W = 45,
  parameter int PH_W  = 24,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    trig,
  input logic                    in_valid,
  input logic [FTW_W-1:0]        ftw_in,
  input logic [PH_W-1:0]         pofs_in,
  input logic [FTW_W-1:0]        acc_q,
  input logic [FTW_W-1:0]        ftw_act,
  input logic [PH_W-1:0]         pofs_act,
  input logic [PH_W-1:0]         ph,
  input logic                    lut_vld,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_i,
  input logic signed [OUT_W-1:0] out_q
);
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 2)));

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !in_valid) |=> $stable(acc_q));

  // R4
  trig_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (ph == pofs_in));

  // R6
  word_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> ($stable(ftw_act) && $stable(pofs_act)));

  // R6
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (ftw_act == $past(ftw_in)));

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !in_valid) |=> (acc_q == '0));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lut_vld |=> ($stable(out_i) && $stable(out_q)));

  // R9
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != MINV && out_q != MINV));
endmodule

bind iq_ddc iq_ddc_chk #(.FTW_W(FTW_W), .PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .in_valid(in_valid), .ftw_in(ftw_in),
  .pofs_in(pofs_in), .acc_q(acc_q), .ftw_act(ftw_act), .pofs_act(pofs_act),
  .ph(ph), .lut_vld(lut_vld), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/iq_ddc_bench.sv
module iq_ddc_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               trig = 1'b0;
  logic [44:0]        ftw_in = '0;
  logic [23:0]        pofs_in = '0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_x = '0;
  logic               out_valid;
  logic signed [15:0] out_i, out_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iq_ddc u_iq_ddc (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ftw_in(ftw_in), .pofs_in(pofs_in),
    .in_valid(in_valid), .in_x(in_x), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  localparam logic [44:0] VF [6] = '{45'h0, 45'h200_0000_0000, 45'h200_0000_0000,
                                     45'h123_4567_89AB, 45'h800_0000_0000, 45'h1FFF_FFFF_FFFF};
  localparam logic [23:0] VP [6] = '{24'h000000, 24'h000000, 24'h400000,
                                     24'hC00000, 24'h155555, 24'hFFFFFF};
  localparam int          VX [6] = '{10000, 20000, -15000, 32767, -32768, 1};
  localparam int          NS = 6;

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    int d;
    n_cmp++;
    d = act - exp;
    if (d > tol || d < -tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent model: real trigonometry on the phase index
  task automatic model(input int n, input logic [44:0] f, input logic [23:0] po,
                       input int x, output int ei, output int eq);
    longint unsigned acc, ph;
    int p;
    real th;
    acc = (longint'(n) * longint'(f)) & ((64'd1 << 45) - 64'd1);
    ph  = ((acc >> 21) + {40'd0, po}) & 64'hFF_FFFF;
    p   = int'(ph >> 14);
    th  = 6.283185307179586 * (real'(p) + 0.5) / 1024.0;
    ei  = int'(real'(x) * 32767.0 * $cos(th) / 32768.0);
    eq  = int'(-real'(x) * 32767.0 * $sin(th) / 32768.0);
  endtask

  task automatic pulse(input logic [44:0] f, input logic [23:0] po);
    @(negedge clk);
    trig = 1'b1; ftw_in = f; pofs_in = po;
    @(negedge clk);
    trig = 1'b0; ftw_in = ~f; pofs_in = ~po;  // later changes must be ignored
  endtask

  task automatic send(input int x, output int oi, output int oq, output bit lat_ok);
    bit early;
    @(negedge clk);
    in_valid = 1'b1; in_x = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    early = out_valid;
    @(negedge clk);
    lat_ok = !early && out_valid;
    oi = out_i; oq = out_q;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int oi, oq, ei, eq, ri, rq;
    bit lat;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0, 0);
    chk("R1 out_i in reset", int'(out_i), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_q after reset", int'(out_q), 0, 0);

    // R6: words are zero before any trigger, so every sample sits at index 0
    send(1000, oi, oq, lat);
    model(0, 45'h0, 24'h0, 1000, ei, eq);
    chk("R6 reset words I", oi, ei, 2);
    send(1000, oi, oq, lat);
    chk("R6 reset words second I", oi, ei, 2);

    // table-driven walk: trigger, then successive samples
    for (int v = 0; v < 6; v++) begin
      pulse(VF[v], VP[v]);
      for (int n = 0; n < NS; n++) begin
        send(VX[v], oi, oq, lat);
        model(n, VF[v], VP[v], VX[v], ei, eq);
        chk("R2 latency", int'(lat), 1, 0);
        chk("R3 R5 R6 I", oi, ei, 2);
        chk("R3 R5 R6 Q", oq, eq, 2);
        if (v == 3 && n == 4) begin ri = oi; rq = oq; end
      end
    end

    // R7: repeat shot 3 and compare sample 4 exactly
    pulse(VF[3], VP[3]);
    for (int n = 0; n < 5; n++) send(VX[3], oi, oq, lat);
    chk("R7 repeat I", oi, ri, 0);
    chk("R7 repeat Q", oq, rq, 0);

    // R7: sample in the trigger cycle uses n=0 and the new words
    @(negedge clk);
    trig = 1'b1; ftw_in = 45'h200_0000_0000; pofs_in = 24'h200000;
    in_valid = 1'b1; in_x = 16'sd9000;
    @(negedge clk);
    trig = 1'b0; in_valid = 1'b0; ftw_in = '0; pofs_in = '0;
    @(negedge clk);
    model(0, 45'h200_0000_0000, 24'h200000, 9000, ei, eq);
    chk("R7 same-cycle I", int'(out_i), ei, 2);
    chk("R7 same-cycle Q", int'(out_q), eq, 2);
    send(9000, oi, oq, lat);
    model(1, 45'h200_0000_0000, 24'h200000, 9000, ei, eq);
    chk("R3 next after trigger Q", oq, eq, 2);

    // R8 / R2: outputs hold and valid drops after a single result
    @(negedge clk);
    chk("R2 valid one cycle", int'(out_valid), 0, 0);
    repeat (3) @(negedge clk);
    chk("R8 hold I", int'(out_i), oi, 0);
    chk("R8 hold Q", int'(out_q), oq, 0);

    // R4: 180 degree offset flips the sign
    pulse(45'h0, 24'h800000);
    send(12000, oi, oq, lat);
    model(0, 45'h0, 24'h800000, 12000, ei, eq);
    chk("R4 half-turn I", oi, ei, 2);
    chk("R4 half-turn Q", oq, eq, 2);

    // R9 / R5: most negative input at full cosine
    pulse(45'h0, 24'h0);
    send(-32768, oi, oq, lat);
    model(0, 45'h0, 24'h0, -32768, ei, eq);
    chk("R5 full-scale I", oi, ei, 2);
    chk("R9 not minimum", int'(oi == -32768), 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule